// File: doc/BRIEF.md
# Bit-Serial Unsigned Magnitude Comparator

This block decides whether one unsigned operand is greater than, less than or equal to another. It does this with a single one-bit comparison cell that it reuses over several clock cycles, instead of building one cell per bit. A start strobe captures both operands into two shift registers. The registers then feed the cell one bit pair per clock, most significant bit first. A two-flop state register holds the running verdict and feeds it back into the cell. Once the cell holds a verdict of greater or less, that verdict stays fixed. While the verdict is still "equal so far", the next bit pair decides.

A small sequencer counts the bit positions. When the count reaches its last value, the sequencer stops the shifters. After the final bit pair has been captured, it raises `ready`. The verdict then stays on `gt`/`lt` until the next start. The result interface has no back-pressure: the result simply stays valid while `ready` is high. A new start may be issued at any time, including during a comparison that is still running, and it always wins.

Top module: `serial_mag_cmp`

## Requirements
- R1: While `rst_n` is low, `gt`, `lt` and `ready` are all 0.
- R2: On a clock edge where `start` is 1, both operands are captured and the verdict is cleared. After that edge, `gt`=0, `lt`=0 and `ready`=0.
- R3: `ready` rises after exactly WIDTH clock edges, counted from the last edge that sampled `start` high. It is 0 after each of the edges before that.
- R4: When `ready` is 1, `gt` is 1 exactly when `opa` > `opb` as unsigned integers.
- R5: When `ready` is 1, `lt` is 1 exactly when `opa` < `opb`. With equal operands, both `gt` and `lt` are 0.
- R6: `gt` and `lt` are never 1 at the same time.
- R7: Bits are examined from the most significant bit down. After the first edge following the release of `start`, {`gt`,`lt`} shows only the top bit pair: 2'b10 if opa[MSB]=1 and opb[MSB]=0, 2'b01 for the reverse, and 2'b00 if the two bits are equal. Once either flag is set, it stays set until the comparison ends.
- R8: While `ready` is 1 and `start` is 0, `gt`, `lt` and `ready` hold their values. Changes on `opa`/`opb` have no effect on them.
- R9: A `start` that arrives during a comparison, including on the edge where the last bit is taken, abandons that comparison and restarts from the load. The result then reflects the new operands and follows the timing of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load operands and begin a comparison |
| opa | input | WIDTH | First unsigned operand |
| opb | input | WIDTH | Second unsigned operand |
| gt | output | 1 | Verdict: opa greater than opb |
| lt | output | 1 | Verdict: opa less than opb |
| ready | output | 1 | Verdict is final and held |

## Verification
Two events can fall in the same cycle: a new `start` and the terminal count, which would otherwise raise `ready`. The bench provokes this collision by asserting `start` exactly on the edge where the last bit pair is consumed. It also places `start` at earlier points of a running comparison. In each case it expects `ready` to stay low on the next cycle and expects the later result to match the new operands, with `ready` arriving WIDTH edges after the restart.

// File: rtl/smc_pkg.sv
package smc_pkg;
  // running verdict carried between bit steps
  typedef struct packed {
    logic gt;
    logic lt;
  } verdict_t;

  localparam verdict_t VERDICT_EQ = '{gt: 1'b0, lt: 1'b0};
endpackage

// File: rtl/smc_bit_cell.sv
module smc_bit_cell
  import smc_pkg::*;
(
  input  logic     a_bit,
  input  logic     b_bit,
  input  verdict_t prior,
  output verdict_t next
);
  // a settled inequality from a more significant bit wins; otherwise this bit decides
  always_comb begin
    if (prior.gt || prior.lt) begin
      next = prior;
    end else begin
      next.gt = a_bit & ~b_bit;
      next.lt = ~a_bit & b_bit;
    end
  end
endmodule

// File: rtl/smc_shifter.sv
module smc_shifter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         head
);
  logic [W-1:0] q;
  logic [W-1:0] q_up;

  assign q_up = q << 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= q_up;
  end

  // the top bit faces the cell
  assign head = q[W-1];
endmodule

// File: rtl/smc_seq.sv
module smc_seq #(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic shift,
  output logic step,
  output logic rdy
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] TERM = CW'(W - 1);

  logic          running;
  logic [CW-1:0] cnt;
  logic          at_term;

  assign at_term = (cnt == TERM);
  assign load    = start;
  assign step    = running && !start;
  assign shift   = running && !start && !at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      rdy     <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
      rdy     <= 1'b0;
    end else if (running) begin
      if (at_term) begin
        running <= 1'b0;
        rdy     <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  AST_TERM_GIVES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && at_term) |=> rdy); // R3
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !start) |=> !shift); // R8
endmodule

// File: rtl/serial_mag_cmp.sv
module serial_mag_cmp
  import smc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic             gt,
  output logic             lt,
  output logic             ready
);
  localparam int NOPS = 2;

  logic                       load, shift, step;
  logic [NOPS-1:0][WIDTH-1:0] opnd_in;
  logic [NOPS-1:0]            head;
  verdict_t                   state_q, cell_out;

  assign opnd_in[0] = opa;
  assign opnd_in[1] = opb;

  smc_seq #(.W(WIDTH)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .shift (shift),
    .step  (step),
    .rdy   (ready)
  );

  for (genvar k = 0; k < NOPS; k++) begin : g_opnd
    smc_shifter #(.W(WIDTH)) u_sh (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .shift (shift),
      .din   (opnd_in[k]),
      .head  (head[k])
    );
  end

  smc_bit_cell u_cell (
    .a_bit (head[0]),
    .b_bit (head[1]),
    .prior (state_q),
    .next  (cell_out)
  );

  // feedback pair: cleared on load, captures the cell each active step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= VERDICT_EQ;
    else if (load) state_q <= VERDICT_EQ;
    else if (step) state_q <= cell_out;
  end

  assign gt = state_q.gt;
  assign lt = state_q.lt;

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(gt && lt)); // R6
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!gt && !lt && !ready)); // R2
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> (ready && $stable(gt) && $stable(lt))); // R8
  AST_INEQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (gt || lt)) |=> ($stable(gt) && $stable(lt))); // R7
endmodule

// File: tb/serial_mag_cmp_tb.sv
module serial_mag_cmp_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         gt, lt, ready;
  int           checks = 0;
  int           errors = 0;
  bit           finished = 1'b0;

  always #5 clk = ~clk;

  serial_mag_cmp #(.WIDTH(W)) u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .opa   (opa),
    .opb   (opb),
    .gt    (gt),
    .lt    (lt),
    .ready (ready)
  );

  // {gt,lt} encoding: 2 = greater, 1 = less, 0 = equal
  function automatic int model(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? 2 : ((a < b) ? 1 : 0);
  endfunction

  function automatic int top_model(input logic [W-1:0] a, input logic [W-1:0] b);
    return model({{(W-1){1'b0}}, a[W-1]}, {{(W-1){1'b0}}, b[W-1]});
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // start is sampled on the next edge; returns just after that edge
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    check({gt, lt, ready} == 3'b000, "R2 load clears", {gt, lt, ready}, 0);
    start = 1'b0;
  endtask

  task automatic finish_run(input logic [W-1:0] a, input logic [W-1:0] b);
    int e;
    e = model(a, b);
    @(negedge clk);
    check(int'({gt, lt}) == top_model(a, b), "R7 msb first", {gt, lt}, top_model(a, b));
    check(ready == 1'b0, "R3 early ready", ready, 0);
    for (int i = 0; i < W - 2; i++) begin
      @(negedge clk);
      check(ready == 1'b0, "R3 early ready", ready, 0);
    end
    @(negedge clk);
    check(ready == 1'b1, "R3 ready after W edges", ready, 1);
    check(gt == (e == 2), "R4 greater", gt, (e == 2));
    check(lt == (e == 1), "R5 less", lt, (e == 1));
    check(!(gt && lt), "R6 exclusive", {gt, lt}, e);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check({gt, lt, ready} == 3'b000, "R1 reset", {gt, lt, ready}, 0);
    rst_n = 1'b1;

    // exhaustive operand sweep
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        launch(W'(a), W'(b));
        finish_run(W'(a), W'(b));
      end
    end

    // held result ignores operand changes
    for (int n = 0; n < 20; n++) begin
      logic [W-1:0] a, b;
      int e;
      a = W'($urandom); b = W'($urandom);
      e = model(a, b);
      launch(a, b);
      finish_run(a, b);
      opa = W'($urandom); opb = W'($urandom);
      repeat (1 + $urandom % 3) @(negedge clk);
      check(ready == 1'b1, "R8 ready held", ready, 1);
      check(int'({gt, lt}) == e, "R8 verdict held", {gt, lt}, e);
    end

    // directed collision: restart on the terminal-count edge
    launch(4'b1000, 4'b0111);
    repeat (2) @(negedge clk);
    launch(4'b0011, 4'b0101);
    finish_run(4'b0011, 4'b0101);

    // random restarts during a running comparison (k = 2 hits the terminal edge)
    for (int n = 0; n < 20; n++) begin
      logic [W-1:0] a, b, a2, b2;
      a = W'($urandom); b = W'($urandom);
      a2 = W'($urandom); b2 = W'($urandom);
      launch(a, b);
      repeat ($urandom % 3) @(negedge clk);
      launch(a2, b2);
      finish_run(a2, b2); // R9
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule